// File: doc/BRIEF.md
# GPIO Bank Register File with Per-Pin Masked Writes

This block is one bank of 32 general-purpose pins, organised as four ports of eight pins. Each port owns three writable control registers: a pin-enable register, a drive-enable register and an output-value register. Each port also has a read-only register that returns the synchronised pad level. Software reaches them over a simple 32-bit register bus. A write completes in the cycle it is presented. A read is captured on the same clock edge and is returned one cycle later. The bank sits in a larger address space at a base of `BANK_SEL * BANK_SPAN`. Both the bank span and the alias offset are parameters, because different chip generations use different values.

Each control register also appears a second time, at `ALIAS_OFS` above its normal address. A write through this alias reads byte 1 of the write data as a pin mask and byte 0 as the new pin values. Only the pins whose mask bit is set take the new value. Several agents can therefore flip individual pins without a read-modify-write sequence. A pad is driven only when its pin-enable bit and its drive-enable bit are both set. The pad inputs pass through a two-flop synchroniser before software can read them.

The block has no state machine. Its control is an address decoder that classifies each access into one of four register groups (`GRP_CFG`, `GRP_OE`, `GRP_OUT`, `GRP_IN`), together with a plain or alias flag.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin-enable, drive-enable and output-value bit is 0, `pad_oe` and `pad_out` are all 0, and reads of these registers return 0.
- R2: A plain write replaces all eight bits of the addressed port register with write bits [7:0]. Write bits [31:8] are ignored. The register address is base + group offset + 4 × port, with the group offsets 0x00 for pin-enable, 0x10 for drive-enable, 0x20 for output-value and 0x30 for input. Pin n belongs to port n/8 at bit n mod 8.
- R3: A write to base + `ALIAS_OFS` + group offset + 4 × port changes only the pins whose bit in write byte 1 (the mask) is 1, and sets each of them to the matching bit of write byte 0. A write with a zero mask changes nothing.
- R4: `pad_oe` for a pin is 1 exactly when both its pin-enable bit and its drive-enable bit are 1.
- R5: `pad_out` for a pin follows that pin's output-value bit, and becomes visible after the write's clock edge.
- R6: A read of the input register returns the pad levels through a two-flop synchroniser, whatever the drive-enable state. A read captured at the second rising edge after a pad change still returns the old level. A read captured at the third rising edge returns the new level.
- R7: Writes to the input register change no register and no pad.
- R8: A read at an alias address returns the plain register contents in bits [7:0] and zero in all higher bits.
- R9: Any unmapped address reads as 0, including a misaligned address or the alias position of the input register. A write to an unmapped address changes nothing.
- R10: `bus_rdata` is loaded on the clock edge at which `bus_re` is sampled high. It is 0 in the cycle after an edge at which `bus_re` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad drive enables |

## Verification
The assertions assume that `bus_we` and `bus_re` are never asserted in the same cycle. They also assume that both strobes are at a known level from the first clock edge. Their stability checks on the pads rely on each write lasting exactly one cycle. The directed bench drives every access at the falling edge, raises exactly one strobe for one cycle and then returns it to 0. Reads are spaced so that each result is sampled before the next edge can clear it. `pad_in` changes only at a falling edge, so the synchroniser latency can be counted in whole cycles.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_PINS = 8;
    localparam int GROUP_STEP = 16;
    localparam int PORT_STEP = 4;

    typedef enum logic [1:0] {
        GRP_CFG = 2'd0,
        GRP_OE  = 2'd1,
        GRP_OUT = 2'd2,
        GRP_IN  = 2'd3
    } grp_e;

    typedef struct packed {
        logic plain_hit;
        logic alias_hit;
        grp_e grp;
    } dec_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NPORTS = 4,
    parameter int BASE = 0,
    parameter int ALIAS_OFS = 'h80,
    localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [PIDX_W-1:0] port
);
    always_comb begin
        dec  = '0;
        port = '0;
        for (int p = 0; p < NPORTS; p++) begin
            for (int g = 0; g < 4; g++) begin
                if (addr == ADDR_W'(BASE + g * GROUP_STEP + p * PORT_STEP)) begin
                    dec.plain_hit = 1'b1;
                    dec.grp       = grp_e'(2'(g));
                    port          = PIDX_W'(p);
                end
                if (g != 3 &&
                    addr == ADDR_W'(BASE + ALIAS_OFS + g * GROUP_STEP + p * PORT_STEP)) begin
                    dec.alias_hit = 1'b1;
                    dec.grp       = grp_e'(2'(g));
                    port          = PIDX_W'(p);
                end
            end
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cfg,
    input  logic         wr_oe,
    input  logic         wr_out,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cfg_q,
    output logic [W-1:0] oe_q,
    output logic [W-1:0] out_q
);
    function automatic logic [W-1:0] merge(input logic [W-1:0] cur,
                                           input logic [W-1:0] m,
                                           input logic [W-1:0] v);
        return (cur & ~m) | (v & m);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            oe_q  <= '0;
            out_q <= '0;
        end else begin
            if (wr_cfg) cfg_q <= merge(cfg_q, wr_mask, wr_val);
            if (wr_oe)  oe_q  <= merge(oe_q, wr_mask, wr_val);
            if (wr_out) out_q <= merge(out_q, wr_mask, wr_val);
        end
    end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NPORTS = 4,
    parameter int BANK_SEL = 0,
    parameter int BANK_SPAN = 'h100,
    parameter int ALIAS_OFS = 'h80,
    localparam int NPINS = NPORTS * PORT_PINS,
    localparam int BASE = BANK_SEL * BANK_SPAN,
    localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    dec_t                 dec;
    logic [PIDX_W-1:0]    port_sel;
    logic                 wr_ok;
    logic [PORT_PINS-1:0] wr_mask;
    logic [PORT_PINS-1:0] wr_val;
    logic [NPINS-1:0]     in_sync;
    logic [NPINS-1:0]     cfg_all, oe_all, out_all;
    logic [PORT_PINS-1:0] rd_byte;

    gpio_addr_decode #(
        .ADDR_W(ADDR_W), .NPORTS(NPORTS), .BASE(BASE), .ALIAS_OFS(ALIAS_OFS)
    ) u_dec (
        .addr(bus_addr), .dec(dec), .port(port_sel)
    );

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
    );

    // Writes reach only control groups; input group and unmapped space are dropped.
    always_comb begin
        wr_ok   = bus_we && ((dec.plain_hit && dec.grp != GRP_IN) || dec.alias_hit);
        wr_mask = dec.alias_hit ? bus_wdata[15:8] : '1;
        wr_val  = bus_wdata[7:0];
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic sel;
        assign sel = wr_ok && (port_sel == PIDX_W'(p));

        gpio_port_regs #(.W(PORT_PINS)) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_cfg (sel && dec.grp == GRP_CFG),
            .wr_oe  (sel && dec.grp == GRP_OE),
            .wr_out (sel && dec.grp == GRP_OUT),
            .wr_mask(wr_mask),
            .wr_val (wr_val),
            .cfg_q  (cfg_all[p*PORT_PINS +: PORT_PINS]),
            .oe_q   (oe_all[p*PORT_PINS +: PORT_PINS]),
            .out_q  (out_all[p*PORT_PINS +: PORT_PINS])
        );
    end

    assign pad_oe  = cfg_all & oe_all;
    assign pad_out = out_all;

    always_comb begin
        rd_byte = '0;
        if (dec.plain_hit || dec.alias_hit) begin
            unique case (dec.grp)
                GRP_CFG: rd_byte = cfg_all[port_sel*PORT_PINS +: PORT_PINS];
                GRP_OE:  rd_byte = oe_all[port_sel*PORT_PINS +: PORT_PINS];
                GRP_OUT: rd_byte = out_all[port_sel*PORT_PINS +: PORT_PINS];
                GRP_IN:  rd_byte = in_sync[port_sel*PORT_PINS +: PORT_PINS];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= bus_re ? {24'd0, rd_byte} : 32'd0;
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int ADDR_W = 12,
    parameter int NPINS = 32,
    parameter int BASE = 0,
    parameter int ALIAS_OFS = 'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe
);
    localparam logic [ADDR_W-1:0] OUT0_ALIAS = ADDR_W'(BASE + ALIAS_OFS + 'h20);
    localparam logic [ADDR_W-1:0] IN0_PLAIN  = ADDR_W'(BASE + 'h30);

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> bus_rdata == 32'd0); // R10

    AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> bus_rdata[31:8] == 24'd0); // R8

    AST_NO_WRITE_PADS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_out) && $stable(pad_oe)); // R2

    AST_ZERO_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OUT0_ALIAS && bus_wdata[15:8] == 8'd0)
        |=> $stable(pad_out)); // R3

    AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == IN0_PLAIN) |=> $stable(pad_out) && $stable(pad_oe)); // R7
endmodule

bind gpio_bank gpio_bank_chk #(
    .ADDR_W(ADDR_W), .NPINS(NPINS), .BASE(BASE), .ALIAS_OFS(ALIAS_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_re = 1'b0;
    logic [31:0]       bus_rdata;
    logic [31:0]       pad_in = '0;
    logic [31:0]       pad_out;
    logic [31:0]       pad_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        bus_read(12'h004, r);
        check("R1 cfg read", r, 32'h0);
    endtask

    task automatic t_plain();
        logic [31:0] r;
        bus_write(12'h004, 32'hFFFF_FFA5);
        bus_read(12'h004, r);
        check("R2 cfg port1", r, 32'h0000_00A5);
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 32'h0);
        bus_write(12'h014, 32'h0000_00FF);
        check("R4 pad_oe", pad_oe, 32'h0000_A500);
        bus_write(12'h024, 32'h0000_003C);
        check("R5 pad_out port1", pad_out, 32'h0000_3C00);
        bus_write(12'h02C, 32'h0000_0081);
        check("R5 pad_out port3", pad_out, 32'h8100_3C00);
    endtask

    task automatic t_masked();
        logic [31:0] r;
        bus_write(12'h0A4, 32'h0000_0FF0);
        check("R3 low nibble cleared", pad_out, 32'h8100_3000);
        bus_write(12'h0A4, 32'h0000_F0F0);
        check("R3 high nibble set", pad_out, 32'h8100_F000);
        bus_write(12'h0A4, 32'h0000_00FF);
        check("R3 zero mask", pad_out, 32'h8100_F000);
        bus_read(12'h0A4, r);
        check("R8 alias read", r, 32'h0000_00F0);
        bus_write(12'h084, 32'h0000_0100);
        check("R4 cfg alias clears pin 8", pad_oe, 32'h0000_A400);
    endtask

    task automatic t_input();
        logic [31:0] r;
        pad_in = 32'h1234_5678;
        repeat (3) @(negedge clk);
        bus_read(12'h030, r);
        check("R6 in port0", r, 32'h78);
        bus_read(12'h034, r);
        check("R6 in port1 driven", r, 32'h56);
        pad_in[7:0] = 8'h99;
        bus_read(12'h030, r);
        check("R6 first edge old", r, 32'h78);
        bus_read(12'h030, r);
        check("R6 second edge old", r, 32'h78);
        bus_read(12'h030, r);
        check("R6 third edge new", r, 32'h99);
        bus_write(12'h030, 32'h0000_FFFF);
        bus_read(12'h030, r);
        check("R7 input unchanged", r, 32'h99);
        check("R7 pads unchanged", pad_out, 32'h8100_F000);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        bus_read(12'h0B0, r);
        check("R9 input alias", r, 32'h0);
        bus_read(12'h006, r);
        check("R9 misaligned", r, 32'h0);
        bus_write(12'h400, 32'h0000_FFFF);
        bus_write(12'h026, 32'h0000_00FF);
        check("R9 pad_out", pad_out, 32'h8100_F000);
        check("R9 pad_oe", pad_oe, 32'h0000_A400);
        bus_read(12'h004, r);
        check("R9 cfg held", r, 32'h0000_00A4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_masked();
        t_input();
        t_unmapped();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule